// File: doc/BRIEF.md
# Lagged Sample Mismatch Counter

This block sits behind the sampling flip-flop of an oscillator-based random source. It takes the raw one-bit stream, where every enabled clock carries one sample and no sample is skipped. It counts how many times a sample differs from the sample taken a programmable lag of M samples later. A shift register holds the recent samples. The sample that is M positions back in it is XORed with the sample arriving now.

The counts are gathered over back-to-back windows of N compared samples. At the end of each window the raw number of mismatches is presented on the count output, together with a one-cycle strobe, for a statistics unit further downstream. A start request begins a run of K windows. When the last window has been reported, the block goes idle, raises a done flag and waits for the next start request.

Top module: `lag_mismatch_counter`

## Requirements
- R1: For every compared sample, the mismatch term is the arriving bit XOR the bit that arrived exactly `lag_cfg` enabled samples earlier. The reported count is the sum of these terms over the window.
- R2: A window closes on its `win_cfg`-th compared sample. `cnt_vld` is high for the single cycle after the clock edge that accepted that sample, and `cnt_out` carries the raw count in that cycle. The count is not normalised.
- R3: Windows follow each other with no overlap and no gap. The accumulator restarts from zero for the sample that comes after a window closes. A run delivers exactly K strobes, even when `smp_en` has gaps.
- R4: After reset, and after any change of `lag_cfg`, no sample is compared and the window does not advance until `lag_cfg` new samples are held in the delay line. A sample that arrives in the cycle the change is seen is discarded.
- R5: `cnt_out` changes only together with `cnt_vld`, and holds its value between strobes. It is wide enough that a count never exceeds `win_cfg`.
- R6: The K-th strobe, `busy` falling and `done` rising all happen on the same clock edge. `busy` and `done` are never high together.
- R7: A `start` while idle or done sets `busy` on the next edge, clears `done` and begins a new run from window zero. A `start` while busy is ignored, and the run continues with no change to its windows.
- R8: Samples taken while the block is not busy fill the delay line, but they are never counted and never cause a strobe.
- R9: After reset, `cnt_out` is 0 and `cnt_vld`, `busy` and `done` are low.
- R10: A cycle with `smp_en` low does not shift the delay line and does not change the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Qualifies `smp_bit` as a new sample |
| smp_bit | input | 1 | Raw sampled bit |
| lag_cfg | input | LAG_W | Comparison distance M, in the range 1 to LAG_MAX |
| win_cfg | input | CNT_W | Window length N, in the range 1 to WIN_MAX |
| start | input | 1 | Begins a run of RUN_LEN windows |
| cnt_out | output | CNT_W | Raw mismatch count of the last window |
| cnt_vld | output | 1 | One-cycle strobe for a new count |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |

## Verification
The bench builds the block with LAG_MAX=16, WIN_MAX=15 and RUN_LEN=3. With these values it can sweep every lag from N+1 to 16 for window lengths 1, 2, 3, 7 and 15. Each run of this small configuration takes only tens of cycles, so a random, an alternating and a constant bit pattern can each go through a full fill and three windows. The lag changes between runs, so every run exercises the refill, including the first window after it. Some runs add enable gaps and a start request in the middle of the run. The bench also repeats a run without a lag change, so a run starts from an already full delay line.

// File: rtl/lag_mm_pkg.sv
package lag_mm_pkg;

    typedef enum logic [1:0] {
        RUN_IDLE   = 2'd0,
        RUN_ACTIVE = 2'd1,
        RUN_DONE   = 2'd2
    } run_state_e;

endpackage

// File: rtl/lag_mm_line.sv
module lag_mm_line #(
    parameter int LAG_MAX = 1024,
    parameter int LAG_W   = $clog2(LAG_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic             smp_bit,
    input  logic [LAG_W-1:0] lag,
    output logic             cmp_vld,
    output logic             cmp_diff
);

    typedef struct packed {
        logic [LAG_MAX-1:0] line;
        logic [LAG_W-1:0]   fill;
        logic [LAG_W-1:0]   lag;
    } line_t;

    line_t s_d, s_q;

    logic [LAG_MAX-1:0] tap_hit;
    logic               tail;
    logic               lag_chg;

    // one-hot tap select: position i holds the bit from i+1 samples back
    for (genvar i = 0; i < LAG_MAX; i++) begin : g_tap
        assign tap_hit[i] = (lag == LAG_W'(i + 1)) & s_q.line[i];
    end

    assign tail    = |tap_hit;
    assign lag_chg = (lag != s_q.lag);

    always_comb begin
        s_d     = s_q;
        s_d.lag = lag;
        if (lag_chg) begin
            s_d.fill = '0;
        end else if (smp_en && (s_q.fill != LAG_W'(LAG_MAX))) begin
            s_d.fill = s_q.fill + LAG_W'(1);
        end
        if (smp_en) begin
            s_d.line = LAG_MAX'({s_q.line, smp_bit});
        end
        cmp_vld  = smp_en && !lag_chg && (lag != '0) && (s_q.fill >= lag);
        cmp_diff = smp_bit ^ tail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/lag_mm_window.sv
module lag_mm_window #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas,
    input  logic             diff,
    input  logic             clear,
    input  logic [CNT_W-1:0] win,
    output logic [CNT_W-1:0] cnt_out,
    output logic             cnt_vld,
    output logic             win_last
);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] mm;
        logic [CNT_W-1:0] cnt;
        logic             vld;
    } win_t;

    win_t s_d, s_q;

    logic [CNT_W-1:0] pos_inc;
    logic [CNT_W-1:0] sum;

    always_comb begin
        s_d      = s_q;
        s_d.vld  = 1'b0;
        pos_inc  = s_q.pos + CNT_W'(1);
        sum      = s_q.mm + CNT_W'(diff);
        win_last = meas && (pos_inc == win);
        if (clear) begin
            s_d.pos = '0;
            s_d.mm  = '0;
        end else if (meas) begin
            if (win_last) begin
                s_d.cnt = sum;
                s_d.vld = 1'b1;
                s_d.pos = '0;
                s_d.mm  = '0;
            end else begin
                s_d.pos = pos_inc;
                s_d.mm  = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_out = s_q.cnt;
    assign cnt_vld = s_q.vld;

endmodule

// File: rtl/lag_mm_run.sv
module lag_mm_run
    import lag_mm_pkg::*;
#(
    parameter int RUN_LEN = 8192,
    parameter int RUN_W   = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic win_last,
    output logic busy,
    output logic done,
    output logic start_ok
);

    typedef struct packed {
        run_state_e       st;
        logic [RUN_W-1:0] k;
    } run_t;

    run_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        start_ok = start && (s_q.st != RUN_ACTIVE);
        if (start_ok) begin
            s_d.st = RUN_ACTIVE;
            s_d.k  = '0;
        end else if ((s_q.st == RUN_ACTIVE) && win_last) begin
            if (s_q.k == RUN_W'(RUN_LEN - 1)) begin
                s_d.st = RUN_DONE;
                s_d.k  = '0;
            end else begin
                s_d.k = s_q.k + RUN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: RUN_IDLE, k: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st == RUN_ACTIVE);
    assign done = (s_q.st == RUN_DONE);

endmodule

// File: rtl/lag_mismatch_counter.sv
module lag_mismatch_counter #(
    parameter int   LAG_MAX = 1024,
    parameter int   WIN_MAX = 255,
    parameter int   RUN_LEN = 8192,
    localparam int  LAG_W   = $clog2(LAG_MAX + 1),
    localparam int  CNT_W   = $clog2(WIN_MAX + 1),
    localparam int  RUN_W   = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic             smp_bit,
    input  logic [LAG_W-1:0] lag_cfg,
    input  logic [CNT_W-1:0] win_cfg,
    input  logic             start,
    output logic [CNT_W-1:0] cnt_out,
    output logic             cnt_vld,
    output logic             busy,
    output logic             done
);

    logic cmp_vld;
    logic cmp_diff;
    logic win_last;
    logic start_ok;
    logic meas;

    lag_mm_line #(.LAG_MAX(LAG_MAX), .LAG_W(LAG_W)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .smp_bit  (smp_bit),
        .lag      (lag_cfg),
        .cmp_vld  (cmp_vld),
        .cmp_diff (cmp_diff)
    );

    assign meas = cmp_vld && busy;

    lag_mm_window #(.CNT_W(CNT_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .meas     (meas),
        .diff     (cmp_diff),
        .clear    (start_ok),
        .win      (win_cfg),
        .cnt_out  (cnt_out),
        .cnt_vld  (cnt_vld),
        .win_last (win_last)
    );

    lag_mm_run #(.RUN_LEN(RUN_LEN), .RUN_W(RUN_W)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .win_last (win_last),
        .busy     (busy),
        .done     (done),
        .start_ok (start_ok)
    );

endmodule

// File: rtl/lag_mm_checker.sv
module lag_mm_checker #(
    parameter int LAG_W = 5,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LAG_W-1:0] lag_cfg,
    input logic [CNT_W-1:0] win_cfg,
    input logic [CNT_W-1:0] cnt_out,
    input logic             cnt_vld,
    input logic             busy,
    input logic             done
);

    p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_vld |-> (cnt_out <= win_cfg));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_vld |-> $stable(cnt_out));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !cnt_vld);

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_end_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && cnt_vld));

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    p_lag_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lag_cfg != $past(lag_cfg)) |=> !cnt_vld);

endmodule

bind lag_mismatch_counter lag_mm_checker #(.LAG_W(LAG_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .lag_cfg (lag_cfg),
    .win_cfg (win_cfg),
    .cnt_out (cnt_out),
    .cnt_vld (cnt_vld),
    .busy    (busy),
    .done    (done)
);

// File: tb/sim_lag_mismatch_counter.sv
`timescale 1ns/1ps
module sim_lag_mismatch_counter;

    localparam int LAG_MAX = 16;
    localparam int WIN_MAX = 15;
    localparam int RUN_LEN = 3;
    localparam int LAG_W   = $clog2(LAG_MAX + 1);
    localparam int CNT_W   = $clog2(WIN_MAX + 1);

    logic             clk;
    logic             rst_n;
    logic             smp_en;
    logic             smp_bit;
    logic [LAG_W-1:0] lag_cfg;
    logic [CNT_W-1:0] win_cfg;
    logic             start;
    logic [CNT_W-1:0] cnt_out;
    logic             cnt_vld;
    logic             busy;
    logic             done;

    lag_mismatch_counter #(.LAG_MAX(LAG_MAX), .WIN_MAX(WIN_MAX), .RUN_LEN(RUN_LEN)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_bit(smp_bit),
        .lag_cfg(lag_cfg), .win_cfg(win_cfg), .start(start),
        .cnt_out(cnt_out), .cnt_vld(cnt_vld), .busy(busy), .done(done)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;

    // reference model state, as it should be after the last edge
    int    nxt_lag = 3;
    int    nxt_win = 2;
    int    m_lagq = 0;
    int    m_fill = 0;
    int    m_idx = 0;
    bit    hist [0:31];
    bit    m_busy = 0;
    bit    m_done = 0;
    int    m_k = 0;
    int    m_pos = 0;
    int    m_mm = 0;
    int    m_cnt = 0;
    bit    m_vld = 0;
    bit    m_first = 0;
    string m_vtag = "R8 no strobe while idle";
    string val_tag = "R1 mismatch count";
    int    act_strobes = 0;
    bit    alt = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input bit en, input bit b, input bit st);
        bit changed;
        bit cmp_ok;
        bit diff;
        bit was_busy;
        smp_en  = en;
        smp_bit = b;
        start   = st;
        lag_cfg = LAG_W'(nxt_lag);
        win_cfg = CNT_W'(nxt_win);
        changed  = (nxt_lag != m_lagq);
        cmp_ok   = en && !changed && (nxt_lag != 0) && (m_fill >= nxt_lag);
        diff     = b ^ hist[(m_idx - nxt_lag) & 31];
        was_busy = m_busy;
        m_vld    = 0;
        if (st && !m_busy) begin
            m_busy = 1; m_done = 0; m_k = 0; m_pos = 0; m_mm = 0; m_first = 1;
        end else if (cmp_ok && m_busy) begin
            m_pos++;
            m_mm += int'(diff);
            if (m_pos == nxt_win) begin
                m_cnt = m_mm; m_vld = 1; m_pos = 0; m_mm = 0; m_k++;
                if (m_k == RUN_LEN) begin
                    m_busy = 0; m_done = 1; m_k = 0;
                end
            end
        end
        if (m_vld && m_first) m_vtag = "R4 first window after fill";
        else if (!was_busy)   m_vtag = "R8 no strobe while idle";
        else                  m_vtag = "R2 strobe timing";
        if (m_vld) m_first = 0;
        if (changed) begin
            m_fill = 0;
        end else if (en) begin
            hist[m_idx & 31] = b;
            m_idx++;
            if (m_fill < LAG_MAX) m_fill++;
        end
        m_lagq = nxt_lag;
    endtask

    task automatic step(input bit en, input bit b, input bit st);
        @(negedge clk);
        chk(cnt_vld == m_vld, m_vtag, int'(cnt_vld), int'(m_vld));
        if (m_vld) begin
            chk(int'(cnt_out) == m_cnt, val_tag, int'(cnt_out), m_cnt);
            chk(int'(cnt_out) <= nxt_win, "R5 no overflow", int'(cnt_out), nxt_win);
        end else begin
            chk(int'(cnt_out) == m_cnt, "R5 count held", int'(cnt_out), m_cnt);
        end
        if (cnt_vld) act_strobes++;
        chk(busy == m_busy, "R7 busy", int'(busy), int'(m_busy));
        chk(done == m_done, "R6 done", int'(done), int'(m_done));
        drive(en, b, st);
    endtask

    function automatic bit gen_bit(input int pat);
        if (pat == 0) return 1'($urandom % 2);
        if (pat == 1) begin
            alt = ~alt;
            return alt;
        end
        return 1'b1;
    endfunction

    task automatic run_cfg(input int lg, input int w, input int pat, input bit gaps);
        int s0;
        int guard;
        bit en;
        nxt_lag = lg;
        nxt_win = w;
        val_tag = gaps ? "R10 count with enable gaps" : "R1 mismatch count";
        step(0, 0, 0);
        step(0, 0, 0);
        for (int i = 0; i < 4; i++) step(1, gen_bit(pat), 0);
        step(0, 0, 1);
        s0 = act_strobes;
        guard = 0;
        while (m_busy && guard < 400) begin
            en = gaps ? (($urandom % 4) != 0) : 1'b1;
            step(en, en ? gen_bit(pat) : 1'b0, guard == lg + 2);
            guard++;
        end
        step(0, 0, 0);
        chk(act_strobes - s0 == RUN_LEN, "R3 windows per run", act_strobes - s0, RUN_LEN);
    endtask

    initial begin
        int wl [5] = '{1, 2, 3, 7, 15};
        rst_n = 0; smp_en = 0; smp_bit = 0; start = 0;
        lag_cfg = LAG_W'(nxt_lag); win_cfg = CNT_W'(nxt_win);
        repeat (3) @(negedge clk);
        chk(cnt_out == '0, "R9 reset count", int'(cnt_out), 0);
        chk(cnt_vld == 1'b0, "R9 reset strobe", int'(cnt_vld), 0);
        chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
        chk(done == 1'b0, "R9 reset done", int'(done), 0);
        rst_n = 1;
        drive(0, 0, 0);
        foreach (wl[wi]) begin
            for (int lg = wl[wi] + 1; lg <= LAG_MAX; lg++) begin
                run_cfg(lg, wl[wi], (lg + wl[wi]) % 3, 1'(lg % 2));
            end
        end
        run_cfg(5, 3, 0, 0);
        run_cfg(5, 3, 1, 0);
        run_cfg(9, 4, 0, 1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog: run never completed actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule